// File: doc/BRIEF.md
# Three-Channel Prescaled Interval Timer

This peripheral holds three independent 16-bit up-counters behind one synchronous register port. Each channel picks one of two count-qualifier inputs as its time base. It can divide that base by a power of two, and it runs either free (wrapping past 0xFFFF) or in interval mode, where it returns to zero once it has reached a programmed value. Both kinds of rollover raise a pending event bit. Reading the channel's status register returns the pending bits and clears them. Each channel drives its own interrupt line from the pending bits its enable register allows through.

Software sets a channel's time base, interval and enables. It then writes the counter control register with the restart bit set and the stop bit clear, and services the interrupt by reading the status register. The registers of one kind sit next to each other with a 4-byte step per channel, so channel n of a register kind lives at that kind's base plus 4*n.

Top module: `tri_interval_timer`

## Requirements
- R1: After reset, every counter control register reads 0x01 (stopped) and every other register reads 0. Counters stay at 0 and all interrupt lines are low.
- R2: In free mode (counter control bit 1 = 0), a running counter advances by one on each prescaled tick. From 0xFFFF it goes to 0 and sets status bit 4 (overflow event).
- R3: In interval mode (counter control bit 1 = 1), a counter equal to the interval register returns to 0 on the next tick and sets status bit 0 (interval event). With an interval of 0, the counter stays at 0 and the event is raised on every tick.
- R4: Clock control bit 0 enables prescaling and bits 4:1 hold an exponent P. When enabled, the counter advances once every 2^(P+1) selected time-base cycles. When disabled, it advances on every one.
- R5: Clock control bit 5 picks the time base: 0 selects src_tick_i[0], 1 selects src_tick_i[1]. Cycles where the selected input is low do not advance the channel.
- R6: Counter control bit 0 = 1 stops the counter and holds its value. Clearing the bit resumes counting from the held value.
- R7: A counter control write with bit 4 set restarts the counter and the prescaler phase at 0 in that cycle. Bit 4 always reads back as 0.
- R8: A status read returns the bits pending before the read and clears them. An event raised in the same cycle as the read stays pending.
- R9: irq_o[n] is high when any pending status bit of channel n has its matching enable bit set (interrupt enable bits 0 and 4). It is updated on the same edge as the status.
- R10: Register offsets for channel 0 are clock control 0x00, counter control 0x0C, counter value 0x18 (read-only), interval 0x24, status 0x54 and interrupt enable 0x60. Channel n adds 4*n. Unmapped addresses read as 0.
- R11: Read data is registered: bus_rdata_o shows the value in the cycle after bus_rd_i, and 0 after a cycle without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_tick_i | input | 2 | Count qualifiers of the two selectable time bases |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | 8 | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |
| irq_o | output | 3 | Interrupt line per channel |

## Verification
The cycle that matters is one where a status read and a counter event land on the same edge: the read must report the bits pending before that edge while the new event stays set. The bench starts a channel in interval mode with a known interval and no prescaling, then times the status read so that it samples on the exact edge where the counter wraps. It expects 0 from that read and the interval bit from the read that follows it. A design where the read clear overrides the new event returns 0 twice, and the bench flags it.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int CNT_W   = 16;
  localparam int PEXP_W  = 4;
  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 8;
  localparam int STEP    = 4;

  // register kind bases for channel 0
  localparam int OFF_CLK = 'h00;
  localparam int OFF_CTL = 'h0C;
  localparam int OFF_VAL = 'h18;
  localparam int OFF_IVL = 'h24;
  localparam int OFF_STS = 'h54;
  localparam int OFF_IEN = 'h60;

  // internal event vector positions
  localparam int EV_IVL = 0;
  localparam int EV_OVF = 1;

  typedef struct packed {
    logic              src_sel;
    logic [PEXP_W-1:0] pexp;
    logic              pre_en;
    logic              stop;
    logic              ivl_mode;
    logic [CNT_W-1:0]  ivl;
    logic [1:0]        ien;
  } chan_cfg_t;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
  import tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              src_tick,
  input  logic              run,
  input  logic              pre_en,
  input  logic [PEXP_W-1:0] pexp,
  input  logic              clr,
  output logic              tick
);
  localparam int PH_W = 2 ** PEXP_W;

  logic [PH_W-1:0] ph_q, ph_n;
  logic [PH_W:0]   lim_w;
  logic [PH_W-1:0] lim;
  logic            step;
  logic            term;

  always_comb begin
    lim_w = ({{PH_W{1'b0}}, 1'b1} << ({1'b0, pexp} + 5'd1)) - 1'b1;
    lim   = lim_w[PH_W-1:0];
    step  = run && src_tick;
    term  = (ph_q >= lim);
    tick  = step && (!pre_en || term);
    ph_n  = ph_q;
    if (clr)                 ph_n = '0;
    else if (step && pre_en) ph_n = term ? '0 : ph_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= '0;
    else        ph_q <= ph_n;
  end

  // R7
  ph_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> ph_q == '0);

  // R6
  ph_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !clr) |=> $stable(ph_q));
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
  import tmr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             clr,
  input  logic             ivl_mode,
  input  logic [CNT_W-1:0] ivl,
  input  logic [1:0]       ien,
  input  logic             rd_clr,
  output logic [CNT_W-1:0] cnt_o,
  output logic [1:0]       sts_o,
  output logic             irq_o
);
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [1:0]       sts_q, sts_n;
  logic             irq_q, irq_n;
  logic [1:0]       evt;

  always_comb begin
    cnt_n = cnt_q;
    evt   = '0;
    if (clr) begin
      cnt_n = '0;
    end else if (tick) begin
      if (ivl_mode && cnt_q == ivl) begin
        cnt_n       = '0;
        evt[EV_IVL] = 1'b1;
      end else if (cnt_q == {CNT_W{1'b1}}) begin
        cnt_n       = '0;
        evt[EV_OVF] = 1'b1;
      end else begin
        cnt_n = cnt_q + 1'b1;
      end
    end
    sts_n = (rd_clr ? 2'b00 : sts_q) | evt;
    irq_n = |(sts_n & ien);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sts_q <= '0;
      irq_q <= 1'b0;
    end else begin
      cnt_q <= cnt_n;
      sts_q <= sts_n;
      irq_q <= irq_n;
    end
  end

  assign cnt_o = cnt_q;
  assign sts_o = sts_q;
  assign irq_o = irq_q;

  // R3
  ivl_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt[EV_IVL] |=> (cnt_q == '0) && sts_q[EV_IVL]);

  // R8
  evt_survives_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && evt[EV_OVF]) |=> sts_q[EV_OVF]);

  // R9
  irq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && evt == 2'b00) |=> !irq_o);

  // R2
  no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !clr) |=> $stable(cnt_q));
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int NUM_CH = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [CNT_W-1:0]  cnt_i   [NUM_CH],
  input  logic [1:0]        sts_i   [NUM_CH],
  output chan_cfg_t         cfg_o   [NUM_CH],
  output logic              restart_o [NUM_CH],
  output logic              stsclr_o  [NUM_CH],
  output logic [DATA_W-1:0] rdata_o
);
  chan_cfg_t         cfg_q [NUM_CH];
  chan_cfg_t         cfg_n [NUM_CH];
  logic [DATA_W-1:0] rdata_q, rdata_n;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input int base, input int ch);
    return a == ADDR_W'(base + STEP * ch);
  endfunction

  always_comb begin
    rdata_n = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      cfg_n[c]     = cfg_q[c];
      restart_o[c] = wr_i && hit(addr_i, OFF_CTL, c) && wdata_i[4];
      stsclr_o[c]  = rd_i && hit(addr_i, OFF_STS, c);
      if (wr_i) begin
        if (hit(addr_i, OFF_CLK, c)) begin
          cfg_n[c].pre_en  = wdata_i[0];
          cfg_n[c].pexp    = wdata_i[PEXP_W:1];
          cfg_n[c].src_sel = wdata_i[5];
        end
        if (hit(addr_i, OFF_CTL, c)) begin
          cfg_n[c].stop     = wdata_i[0];
          cfg_n[c].ivl_mode = wdata_i[1];
        end
        if (hit(addr_i, OFF_IVL, c)) cfg_n[c].ivl = wdata_i[CNT_W-1:0];
        if (hit(addr_i, OFF_IEN, c)) cfg_n[c].ien = {wdata_i[4], wdata_i[0]};
      end
      if (rd_i) begin
        if (hit(addr_i, OFF_CLK, c))
          rdata_n = DATA_W'({cfg_q[c].src_sel, cfg_q[c].pexp, cfg_q[c].pre_en});
        if (hit(addr_i, OFF_CTL, c))
          rdata_n = DATA_W'({cfg_q[c].ivl_mode, cfg_q[c].stop});
        if (hit(addr_i, OFF_VAL, c)) rdata_n = DATA_W'(cnt_i[c]);
        if (hit(addr_i, OFF_IVL, c)) rdata_n = DATA_W'(cfg_q[c].ivl);
        if (hit(addr_i, OFF_STS, c))
          rdata_n = DATA_W'({sts_i[c][EV_OVF], 3'b000, sts_i[c][EV_IVL]});
        if (hit(addr_i, OFF_IEN, c))
          rdata_n = DATA_W'({cfg_q[c].ien[1], 3'b000, cfg_q[c].ien[0]});
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NUM_CH; c++) begin
        cfg_q[c]      <= '0;
        cfg_q[c].stop <= 1'b1;
      end
      rdata_q <= '0;
    end else begin
      for (int c = 0; c < NUM_CH; c++) cfg_q[c] <= cfg_n[c];
      rdata_q <= rdata_n;
    end
  end

  assign cfg_o   = cfg_q;
  assign rdata_o = rdata_q;

  // R11
  idle_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_i |=> rdata_o == '0);
endmodule

// File: rtl/tri_interval_timer.sv
module tri_interval_timer
  import tmr_pkg::*;
#(
  parameter int NUM_CH = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        src_tick_i,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic [NUM_CH-1:0] irq_o
);
  chan_cfg_t        cfg     [NUM_CH];
  logic             restart [NUM_CH];
  logic             stsclr  [NUM_CH];
  logic [CNT_W-1:0] cnt     [NUM_CH];
  logic [1:0]       sts     [NUM_CH];

  tmr_regs #(.NUM_CH(NUM_CH)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_i      (bus_wr_i),
    .rd_i      (bus_rd_i),
    .addr_i    (bus_addr_i),
    .wdata_i   (bus_wdata_i),
    .cnt_i     (cnt),
    .sts_i     (sts),
    .cfg_o     (cfg),
    .restart_o (restart),
    .stsclr_o  (stsclr),
    .rdata_o   (bus_rdata_o)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic base_tick;
    logic tick;

    assign base_tick = src_tick_i[cfg[g].src_sel];

    tmr_prescaler u_pre (
      .clk      (clk),
      .rst_n    (rst_n),
      .src_tick (base_tick),
      .run      (!cfg[g].stop),
      .pre_en   (cfg[g].pre_en),
      .pexp     (cfg[g].pexp),
      .clr      (restart[g]),
      .tick     (tick)
    );

    tmr_counter u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .clr      (restart[g]),
      .ivl_mode (cfg[g].ivl_mode),
      .ivl      (cfg[g].ivl),
      .ien      (cfg[g].ien),
      .rd_clr   (stsclr[g]),
      .cnt_o    (cnt[g]),
      .sts_o    (sts[g]),
      .irq_o    (irq_o[g])
    );

    // R6
    stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg[g].stop && !restart[g]) |=> $stable(cnt[g]));

    // R7
    restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      restart[g] |=> cnt[g] == '0);
  end
endmodule

// File: tb/tb_tri_interval_timer.sv
module tb_tri_interval_timer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  src_tick_i;
  logic        bus_wr_i, bus_rd_i;
  logic [7:0]  bus_addr_i;
  logic [31:0] bus_wdata_i;
  logic [31:0] bus_rdata_o;
  logic [2:0]  irq_o;

  int n_vec = 0;
  int n_err = 0;
  bit done  = 0;

  tri_interval_timer dut (.*);

  always #2 clk = ~clk;

  function automatic logic [7:0] ra(input int base, input int ch);
    return 8'(base + 4 * ch);
  endfunction

  function automatic int exp_count(input int i, input int lval, input bit imode, input int div);
    int n = i / div;
    return imode ? n % (lval + 1) : n % 65536;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_wr_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
    @(posedge clk); @(negedge clk);
    bus_wr_i = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_rd_i = 1'b1; bus_addr_i = a;
    @(posedge clk); @(negedge clk);
    d = bus_rdata_o;
    bus_rd_i = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(4 * 190000);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, v;
    process::self().srandom(32'd1234);
    rst_n = 1'b0; src_tick_i = 2'b11;
    bus_wr_i = 1'b0; bus_rd_i = 1'b0; bus_addr_i = '0; bus_wdata_i = '0;
    idle(3);
    rst_n = 1'b1;
    idle(2);

    // R1 reset state
    for (int c = 0; c < 3; c++) begin
      rd(ra('h0C, c), d); chk("R1 ctl reset", d, 32'h1);
      rd(ra('h00, c), d); chk("R1 clk reset", d, 0);
      rd(ra('h24, c), d); chk("R1 ivl reset", d, 0);
      rd(ra('h18, c), d); chk("R1 count reset", d, 0);
    end
    idle(20);
    rd(ra('h18, 1), d); chk("R1 count held", d, 0);
    chk("R1 irq reset", {29'd0, irq_o}, 0);

    // R10 unmapped address
    rd(8'h30, d); chk("R10 unmapped", d, 0);
    // R11 no read -> zero
    idle(1); chk("R11 idle rdata", bus_rdata_o, 0);

    // R7 restart bit reads back 0
    wr(ra('h24, 2), 32'd100);
    wr(ra('h0C, 2), 32'h12);
    rd(ra('h0C, 2), d); chk("R7 restart readback", d, 32'h2);
    rd(ra('h24, 2), d); chk("R10 ivl ch2", d, 32'd100);

    // R6 stop and resume (ch0 free)
    wr(ra('h0C, 0), 32'h10);
    idle(10);
    wr(ra('h0C, 0), 32'h1);
    rd(ra('h18, 0), d); chk("R6 stopped value", d, 11);
    idle(20);
    rd(ra('h18, 0), d); chk("R6 held", d, 11);
    wr(ra('h0C, 0), 32'h0);
    idle(5);
    rd(ra('h18, 0), d); chk("R6 resumed", d, 16);

    // R5 time base select on ch1
    wr(ra('h00, 1), 32'h20);
    src_tick_i = 2'b01;
    wr(ra('h0C, 1), 32'h10);
    idle(10);
    rd(ra('h18, 1), d); chk("R5 base low holds", d, 0);
    src_tick_i = 2'b10;
    idle(5);
    rd(ra('h18, 1), d); chk("R5 base selected", d, 5);
    src_tick_i = 2'b11;

    // R4 prescaler
    wr(ra('h00, 1), 32'h01);
    wr(ra('h0C, 1), 32'h10);
    idle(9);
    rd(ra('h18, 1), d); chk("R4 div2", d, 4);
    wr(ra('h00, 1), 32'h05);
    wr(ra('h0C, 1), 32'h10);
    idle(33);
    rd(ra('h18, 1), d); chk("R4 div8", d, 4);

    // R3 interval of zero
    wr(ra('h0C, 1), 32'h1);
    wr(ra('h00, 1), 32'h0);
    rd(ra('h54, 1), d);
    wr(ra('h24, 1), 32'd0);
    wr(ra('h0C, 1), 32'h12);
    idle(7);
    rd(ra('h18, 1), d); chk("R3 zero interval count", d, 0);
    rd(ra('h54, 1), d); chk("R3 zero interval event", d, 32'h1);

    // R8 read/clear colliding with interval event (ch0, L=10)
    wr(ra('h0C, 0), 32'h1);
    rd(ra('h54, 0), d);
    wr(ra('h24, 0), 32'd10);
    wr(ra('h0C, 0), 32'h12);
    idle(10);
    rd(ra('h54, 0), d); chk("R8 read on event edge", d, 0);
    rd(ra('h54, 0), d); chk("R8 event kept", d, 32'h1);
    rd(ra('h54, 0), d); chk("R8 cleared", d, 0);

    // R9 interrupt gating (ch2)
    wr(ra('h0C, 2), 32'h1);
    rd(ra('h54, 2), d);
    wr(ra('h60, 2), 32'h1);
    wr(ra('h24, 2), 32'd3);
    wr(ra('h0C, 2), 32'h12);
    idle(10);
    chk("R9 irq raised", {31'd0, irq_o[2]}, 1);
    chk("R9 irq masked ch0", {31'd0, irq_o[0]}, 0);
    wr(ra('h0C, 2), 32'h3);
    rd(ra('h54, 2), d); chk("R9 status pending", d, 32'h1);
    chk("R9 irq after clear", {31'd0, irq_o[2]}, 0);
    rd(ra('h60, 2), d); chk("R10 ien ch2", d, 32'h1);

    // R2 overflow wrap (ch0 free)
    wr(ra('h0C, 0), 32'h1);
    rd(ra('h54, 0), d);
    wr(ra('h0C, 0), 32'h10);
    idle(65540);
    rd(ra('h18, 0), d); chk("R2 wrapped count", d, 4);
    rd(ra('h54, 0), d); chk("R2 overflow event", d, 32'h10);

    // random programs, all channels
    for (int it = 0; it < 60; it++) begin
      int  ch, lval, wt, pe, div, n2;
      bit  imode;
      ch    = $urandom_range(2, 0);
      lval  = $urandom_range(40, 0);
      wt    = $urandom_range(300, 0);
      imode = 1'($urandom_range(1, 0));
      pe    = $urandom_range(3, 0);
      div   = (pe == 3) ? 1 : (1 << (pe + 1));
      wr(ra('h0C, ch), 32'h1);
      rd(ra('h54, ch), d);
      wr(ra('h00, ch), (pe == 3) ? 32'h0 : (32'(pe) << 1) | 32'h1);
      wr(ra('h24, ch), 32'(lval));
      wr(ra('h0C, ch), imode ? 32'h12 : 32'h10);
      idle(wt);
      rd(ra('h18, ch), v);
      chk(imode ? "R3 random count" : "R2 random count", v, 32'(exp_count(wt, lval, imode, div)));
      n2 = (wt + 1) / div;
      rd(ra('h54, ch), d);
      chk("R8 random status", d, (imode && n2 >= lval + 1) ? 32'h1 : 32'h0);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end
endmodule